// File: doc/BRIEF.md
# Paged Descriptor Ring Address Generator

This block keeps the device-side pointers of three descriptor rings that live in host memory: a request ring that the device drains, and completion and message rings that the device fills. Each ring is spread over a small table of memory pages that need not be contiguous. Software loads the page frame numbers and page counts through a setup port. From then on the block turns each ring pointer into the physical address of the next descriptor.

The ring size is derived from the page count at setup. A pointer keeps counting past the ring size without wrapping. Only its masked value selects a page-table entry and a slot inside that page. For the request ring, the block compares its pointer with the host producer index, so it can report an empty ring. For the message ring, it reports whether there is room from the producer and consumer indices held in the shared state area. Flush strobes hand out the index values that the caller writes back to that state area.

The surrounding logic performs the memory transfers and decodes the descriptors.

Top module: `desc_ring_addr`

## Requirements
- R1: After reset every address, published index, size exponent and state-area address reads zero, and `msg_room_o` is 0.
- R2: A data setup (`cfg_data_i`) loads the request and completion page tables and sets each size exponent to the bit length of (pages × entries-per-page − 1). It clears both pointers and both published indices, sets `state_addr_o` to the state frame number shifted left by `PAGE_SHIFT`, and pulses `data_init_o` high for exactly the following cycle.
- R3: The request address is page_base[idx >> REQ_EPP_LOG2] + (idx mod 2^REQ_EPP_LOG2) × 2^REQ_DSZ_LOG2. Here idx = pointer AND mask, mask = 2^exponent − 1, and page_base = frame number << PAGE_SHIFT.
- R4: `req_addr_o` reads zero, and `req_pop_i` leaves the pointer unchanged, when `req_prod_i` equals the full request pointer or no data setup has been accepted.
- R5: Each accepted pop adds one to the full-width pointer. Addresses therefore repeat with a period of the ring's entry count.
- R6: A completion pop always advances the completion pointer, with no overflow check. Its address follows the R3 mapping with CMP_EPP_LOG2 and CMP_DSZ_LOG2.
- R7: A message setup (`cfg_msg_i`) is ignored unless a data setup has been accepted. When it is accepted, it loads the message page table and exponent, clears the message pointer and `msg_prod_o`, and pulses `msg_init_o`. Message addresses follow R3 with MSG_EPP_LOG2 and MSG_DSZ_LOG2.
- R8: `msg_room_o` is 1 exactly when the message ring is set up and (`msg_prod_i` − `msg_cons_i`) mod 2^IDX_W is less than the message mask + 1.
- R9: The cycle after a flush, `req_cons_o`, `cmp_prod_o` or `msg_prod_o` holds the full pointer value from before any pop in the same cycle.
- R10: In any cycle, cleanup takes priority over data setup, data setup over message setup, and any setup over pops and flushes. A pop or flush in a setup cycle has no effect.
- R11: Cleanup (`cfg_clean_i`) returns every pointer, table entry, exponent, published index and valid state to the R1 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_clean_i | input | 1 | Cleanup strobe |
| cfg_data_i | input | 1 | Data ring setup strobe |
| cfg_msg_i | input | 1 | Message ring setup strobe |
| cfg_state_pfn_i | input | PFN_W | Frame number of the ring-state page |
| cfg_req_pages_i | input | PC_W | Request ring page count |
| cfg_cmp_pages_i | input | PC_W | Completion ring page count |
| cfg_msg_pages_i | input | PC_W | Message ring page count |
| cfg_req_pt_i | input | PT_DEPTH×PFN_W | Request page frame numbers, entry p at bits p×PFN_W |
| cfg_cmp_pt_i | input | PT_DEPTH×PFN_W | Completion page frame numbers |
| cfg_msg_pt_i | input | PT_DEPTH×PFN_W | Message page frame numbers |
| req_pop_i | input | 1 | Consume one request descriptor |
| cmp_pop_i | input | 1 | Fill one completion descriptor |
| msg_pop_i | input | 1 | Fill one message descriptor |
| req_flush_i | input | 1 | Publish request consumer index |
| cmp_flush_i | input | 1 | Publish completion producer index |
| msg_flush_i | input | 1 | Publish message producer index |
| req_prod_i | input | IDX_W | Host request producer index |
| msg_prod_i | input | IDX_W | Message producer index from state area |
| msg_cons_i | input | IDX_W | Message consumer index from state area |
| req_addr_o | output | ADDR_W | Next request descriptor address, zero when empty |
| cmp_addr_o | output | ADDR_W | Next completion descriptor address |
| msg_addr_o | output | ADDR_W | Next message descriptor address |
| msg_room_o | output | 1 | Message ring has a free slot |
| req_cons_o | output | IDX_W | Published request consumer index |
| cmp_prod_o | output | IDX_W | Published completion producer index |
| msg_prod_o | output | IDX_W | Published message producer index |
| req_log2_o | output | LG_W | Request ring size exponent |
| cmp_log2_o | output | LG_W | Completion ring size exponent |
| msg_log2_o | output | LG_W | Message ring size exponent |
| state_addr_o | output | ADDR_W | Ring-state page address |
| data_init_o | output | 1 | One-cycle pulse after an accepted data setup |
| msg_init_o | output | 1 | One-cycle pulse after an accepted message setup |

## Verification
The embedded properties watch the pointer rules on every cycle:
- an empty request pop leaves the pointer alone;
- a completion pop steps by exactly one;
- a flush publishes the pre-pop pointer;
- a setup blocks a concurrent pop;
- a premature message setup is refused;
- an init pulse coincides with cleared pointers.

Only the bench scenarios can show that the address mapping is correct. They sweep each ring more than once around at one, two and four pages, against addresses computed from the page frame numbers. The same holds for the size exponent of a page count that is not a power of two, the modular room test across index wraparound, and the zeroing by cleanup.

// File: rtl/desc_ring_addr.sv
module desc_ring_addr #(
  parameter int PFN_W        = 20,
  parameter int PAGE_SHIFT   = 12,
  parameter int PT_DEPTH     = 4,
  parameter int IDX_W        = 32,
  parameter int REQ_EPP_LOG2 = 5,
  parameter int REQ_DSZ_LOG2 = 7,
  parameter int CMP_EPP_LOG2 = 7,
  parameter int CMP_DSZ_LOG2 = 5,
  parameter int MSG_EPP_LOG2 = 6,
  parameter int MSG_DSZ_LOG2 = 6,
  localparam int ADDR_W = PFN_W + PAGE_SHIFT,
  localparam int PC_W   = $clog2(PT_DEPTH) + 1,
  localparam int PT_W   = PT_DEPTH * PFN_W,
  localparam int LG_W   = $clog2(IDX_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_clean_i,
  input  logic              cfg_data_i,
  input  logic              cfg_msg_i,
  input  logic [PFN_W-1:0]  cfg_state_pfn_i,
  input  logic [PC_W-1:0]   cfg_req_pages_i,
  input  logic [PC_W-1:0]   cfg_cmp_pages_i,
  input  logic [PC_W-1:0]   cfg_msg_pages_i,
  input  logic [PT_W-1:0]   cfg_req_pt_i,
  input  logic [PT_W-1:0]   cfg_cmp_pt_i,
  input  logic [PT_W-1:0]   cfg_msg_pt_i,
  input  logic              req_pop_i,
  input  logic              cmp_pop_i,
  input  logic              msg_pop_i,
  input  logic              req_flush_i,
  input  logic              cmp_flush_i,
  input  logic              msg_flush_i,
  input  logic [IDX_W-1:0]  req_prod_i,
  input  logic [IDX_W-1:0]  msg_prod_i,
  input  logic [IDX_W-1:0]  msg_cons_i,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [ADDR_W-1:0] cmp_addr_o,
  output logic [ADDR_W-1:0] msg_addr_o,
  output logic              msg_room_o,
  output logic [IDX_W-1:0]  req_cons_o,
  output logic [IDX_W-1:0]  cmp_prod_o,
  output logic [IDX_W-1:0]  msg_prod_o,
  output logic [LG_W-1:0]   req_log2_o,
  output logic [LG_W-1:0]   cmp_log2_o,
  output logic [LG_W-1:0]   msg_log2_o,
  output logic [ADDR_W-1:0] state_addr_o,
  output logic              data_init_o,
  output logic              msg_init_o
);

  localparam int PG_W = (PT_DEPTH > 1) ? $clog2(PT_DEPTH) : 1;

  function automatic logic [LG_W-1:0] size_log2(input logic [PC_W-1:0] pages, input int epp_l2);
    logic [IDX_W-1:0] last;
    last = (IDX_W'(pages) << epp_l2) - IDX_W'(1);
    size_log2 = '0;
    for (int b = 0; b < IDX_W; b++)
      if (last[b]) size_log2 = LG_W'(b + 1);
  endfunction

  function automatic logic [ADDR_W-1:0] slot_addr(input logic [PT_W-1:0] pt, input logic [IDX_W-1:0] idx,
                                                  input int epp_l2, input int dsz_l2);
    logic [PG_W-1:0]   pg;
    logic [ADDR_W-1:0] slot;
    logic [ADDR_W-1:0] base;
    pg   = PG_W'(idx >> epp_l2);
    slot = ADDR_W'(idx & ((IDX_W'(1) << epp_l2) - IDX_W'(1)));
    base = {pt[pg*PFN_W +: PFN_W], {PAGE_SHIFT{1'b0}}};
    return base + (slot << dsz_l2);
  endfunction

  logic [PT_W-1:0]  req_pt, cmp_pt, msg_pt;
  logic [IDX_W-1:0] req_ptr, cmp_ptr, msg_ptr;
  logic             data_ok, msg_ok;

  wire any_cfg = cfg_clean_i | cfg_data_i | cfg_msg_i;
  wire [IDX_W-1:0] req_mask = (IDX_W'(1) << req_log2_o) - IDX_W'(1);
  wire [IDX_W-1:0] cmp_mask = (IDX_W'(1) << cmp_log2_o) - IDX_W'(1);
  wire [IDX_W-1:0] msg_mask = (IDX_W'(1) << msg_log2_o) - IDX_W'(1);
  wire req_empty = !data_ok || (req_prod_i == req_ptr);

  assign req_addr_o = req_empty ? '0 : slot_addr(req_pt, req_ptr & req_mask, REQ_EPP_LOG2, REQ_DSZ_LOG2);
  assign cmp_addr_o = slot_addr(cmp_pt, cmp_ptr & cmp_mask, CMP_EPP_LOG2, CMP_DSZ_LOG2);
  assign msg_addr_o = slot_addr(msg_pt, msg_ptr & msg_mask, MSG_EPP_LOG2, MSG_DSZ_LOG2);
  assign msg_room_o = msg_ok && ((msg_prod_i - msg_cons_i) < (msg_mask + IDX_W'(1)));

  always_ff @(posedge clk) begin
    data_init_o <= 1'b0;
    msg_init_o  <= 1'b0;
    if (!rst_n || cfg_clean_i) begin
      req_pt       <= '0;
      cmp_pt       <= '0;
      msg_pt       <= '0;
      req_ptr      <= '0;
      cmp_ptr      <= '0;
      msg_ptr      <= '0;
      req_cons_o   <= '0;
      cmp_prod_o   <= '0;
      msg_prod_o   <= '0;
      req_log2_o   <= '0;
      cmp_log2_o   <= '0;
      msg_log2_o   <= '0;
      state_addr_o <= '0;
      data_ok      <= 1'b0;
      msg_ok       <= 1'b0;
    end else if (cfg_data_i) begin
      req_pt       <= cfg_req_pt_i;
      cmp_pt       <= cfg_cmp_pt_i;
      req_ptr      <= '0;
      cmp_ptr      <= '0;
      req_cons_o   <= '0;
      cmp_prod_o   <= '0;
      req_log2_o   <= size_log2(cfg_req_pages_i, REQ_EPP_LOG2);
      cmp_log2_o   <= size_log2(cfg_cmp_pages_i, CMP_EPP_LOG2);
      state_addr_o <= {cfg_state_pfn_i, {PAGE_SHIFT{1'b0}}};
      data_ok      <= 1'b1;
      data_init_o  <= 1'b1;
    end else if (cfg_msg_i) begin
      if (data_ok) begin
        msg_pt     <= cfg_msg_pt_i;
        msg_ptr    <= '0;
        msg_prod_o <= '0;
        msg_log2_o <= size_log2(cfg_msg_pages_i, MSG_EPP_LOG2);
        msg_ok     <= 1'b1;
        msg_init_o <= 1'b1;
      end
    end else begin
      if (req_pop_i && !req_empty) req_ptr <= req_ptr + IDX_W'(1);
      if (cmp_pop_i)   cmp_ptr    <= cmp_ptr + IDX_W'(1);
      if (msg_pop_i)   msg_ptr    <= msg_ptr + IDX_W'(1);
      if (req_flush_i) req_cons_o <= req_ptr;
      if (cmp_flush_i) cmp_prod_o <= cmp_ptr;
      if (msg_flush_i) msg_prod_o <= msg_ptr;
    end
  end

  AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_pop_i && !any_cfg && req_prod_i == req_ptr) |=> $stable(req_ptr)); // R4
  AST_CMP_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_pop_i && !any_cfg) |=> cmp_ptr == $past(cmp_ptr) + IDX_W'(1)); // R6
  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    data_init_o |-> (req_ptr == '0 && cmp_ptr == '0 && req_cons_o == '0 && cmp_prod_o == '0)); // R2
  AST_MSG_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_msg_i && !cfg_clean_i && !cfg_data_i && !data_ok) |=> !msg_init_o); // R7
  AST_FLUSH_PRE_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_flush_i && !any_cfg) |=> req_cons_o == $past(req_ptr)); // R9
  AST_SETUP_BLOCKS_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_msg_i && !cfg_clean_i && !cfg_data_i && cmp_pop_i) |=> $stable(cmp_ptr)); // R10

endmodule

// File: tb/test_desc_ring_addr.sv
module test_desc_ring_addr;
  localparam int PFN_W = 20, PT_DEPTH = 4, IDX_W = 32, ADDR_W = 32, PC_W = 3, PT_W = 80, LG_W = 6;

  logic clk = 0, rst_n = 0;
  logic cfg_clean_i = 0, cfg_data_i = 0, cfg_msg_i = 0;
  logic [PFN_W-1:0] cfg_state_pfn_i = '0;
  logic [PC_W-1:0] cfg_req_pages_i = '0, cfg_cmp_pages_i = '0, cfg_msg_pages_i = '0;
  logic [PT_W-1:0] cfg_req_pt_i, cfg_cmp_pt_i, cfg_msg_pt_i;
  logic req_pop_i = 0, cmp_pop_i = 0, msg_pop_i = 0;
  logic req_flush_i = 0, cmp_flush_i = 0, msg_flush_i = 0;
  logic [IDX_W-1:0] req_prod_i = '0, msg_prod_i = '0, msg_cons_i = '0;
  logic [ADDR_W-1:0] req_addr_o, cmp_addr_o, msg_addr_o, state_addr_o;
  logic msg_room_o, data_init_o, msg_init_o;
  logic [IDX_W-1:0] req_cons_o, cmp_prod_o, msg_prod_o;
  logic [LG_W-1:0] req_log2_o, cmp_log2_o, msg_log2_o;

  int n_chk = 0, n_bad = 0;

  desc_ring_addr i_desc_ring_addr (.*);

  always #2 clk = ~clk;

  function automatic logic [PFN_W-1:0] pfn_of(int r, int p);
    return PFN_W'(32'h100 * (r + 1) + 17 * p + 3);
  endfunction

  function automatic logic [31:0] exp_addr(int r, int pages, int k, int epp_l2, int dsz_l2);
    int e, idx;
    e = pages << epp_l2;
    idx = k % e;
    return ({12'h0, pfn_of(r, idx >> epp_l2)} << 12) + ((idx % (1 << epp_l2)) << dsz_l2);
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int rp, cp, mp, e, lg, cpub;
    for (int p = 0; p < PT_DEPTH; p++) begin
      cfg_req_pt_i[p*PFN_W +: PFN_W] = pfn_of(0, p);
      cfg_cmp_pt_i[p*PFN_W +: PFN_W] = pfn_of(1, p);
      cfg_msg_pt_i[p*PFN_W +: PFN_W] = pfn_of(2, p);
    end
    repeat (3) tick();
    rst_n = 1;
    req_prod_i = 5;
    #1;
    chk("R1 req_addr", req_addr_o, 0);
    chk("R1 cmp_addr", cmp_addr_o, 0);
    chk("R1 room", msg_room_o, 0);
    chk("R1 log2", req_log2_o, 0);
    chk("R1 state", state_addr_o, 0);
    chk("R1 cons", req_cons_o, 0);

    cfg_msg_i = 1; cfg_msg_pages_i = 1; tick(); cfg_msg_i = 0;
    chk("R7 gated init", msg_init_o, 0);
    chk("R7 gated log2", msg_log2_o, 0);

    for (int s = 0; s < 3; s++) begin
      int pg;
      pg = 1 << s; lg = s;
      cfg_req_pages_i = PC_W'(pg); cfg_cmp_pages_i = PC_W'(pg); cfg_msg_pages_i = PC_W'(pg);
      cfg_state_pfn_i = PFN_W'(32'h55 + pg);
      cfg_data_i = 1; tick(); cfg_data_i = 0;
      chk("R2 init pulse", data_init_o, 1);
      chk("R2 req log2", req_log2_o, 5 + lg);
      chk("R2 cmp log2", cmp_log2_o, 7 + lg);
      chk("R2 state addr", state_addr_o, (32'h55 + pg) << 12);
      chk("R2 req cons", req_cons_o, 0);
      chk("R2 cmp prod", cmp_prod_o, 0);
      cfg_msg_i = 1; tick(); cfg_msg_i = 0;
      chk("R7 init pulse", msg_init_o, 1);
      chk("R7 msg log2", msg_log2_o, 6 + lg);
      chk("R7 msg prod", msg_prod_o, 0);
      tick();
      chk("R2 pulse ends", data_init_o, 0);

      e = pg * 32; rp = 0;
      req_prod_i = 2 * e + 3;
      for (int k = 0; k < 2 * e + 3; k++) begin
        chk("R3 R5 req addr", req_addr_o, exp_addr(0, pg, k, 5, 7));
        req_pop_i = 1; tick(); req_pop_i = 0; rp++;
      end
      chk("R4 empty addr", req_addr_o, 0);
      req_pop_i = 1; tick(); req_pop_i = 0;
      req_flush_i = 1; tick(); req_flush_i = 0;
      chk("R9 R4 req cons", req_cons_o, rp);
      req_prod_i = rp + 1; #1;
      chk("R3 after empty", req_addr_o, exp_addr(0, pg, rp, 5, 7));

      e = pg * 128; cp = 0;
      for (int k = 0; k < 2 * e + 1; k++) begin
        chk("R6 cmp addr", cmp_addr_o, exp_addr(1, pg, k, 7, 5));
        cmp_pop_i = 1; tick(); cmp_pop_i = 0; cp++;
      end
      cmp_pop_i = 1; cmp_flush_i = 1; tick(); cmp_pop_i = 0; cmp_flush_i = 0;
      chk("R9 cmp prod pre-pop", cmp_prod_o, cp);
      cp++; cpub = cp - 1;
      chk("R6 cmp addr after", cmp_addr_o, exp_addr(1, pg, cp, 7, 5));

      e = pg * 64; mp = 0;
      for (int k = 0; k < e + 2; k++) begin
        chk("R7 msg addr", msg_addr_o, exp_addr(2, pg, k, 6, 6));
        msg_pop_i = 1; tick(); msg_pop_i = 0; mp++;
      end
      msg_flush_i = 1; tick(); msg_flush_i = 0;
      chk("R9 msg prod", msg_prod_o, mp);

      msg_cons_i = 100; msg_prod_i = 100 + e - 1; #1;
      chk("R8 room last slot", msg_room_o, 1);
      msg_prod_i = 100 + e; #1;
      chk("R8 full", msg_room_o, 0);
      msg_cons_i = 32'hFFFF_FFF0; msg_prod_i = 32'hFFFF_FFF0 + e - 1; #1;
      chk("R8 wrap room", msg_room_o, 1);
      msg_prod_i = 32'hFFFF_FFEF; #1;
      chk("R8 behind", msg_room_o, 0);

      if (s == 2) begin
        cfg_msg_i = 1; cmp_pop_i = 1; cmp_flush_i = 1; tick();
        cfg_msg_i = 0; cmp_pop_i = 0; cmp_flush_i = 0;
        chk("R10 flush blocked", cmp_prod_o, cpub);
        chk("R10 pop blocked", cmp_addr_o, exp_addr(1, pg, cp, 7, 5));
        chk("R10 msg setup taken", msg_init_o, 1);
      end
    end

    cfg_req_pages_i = 3; cfg_cmp_pages_i = 3; cfg_data_i = 1; tick(); cfg_data_i = 0;
    chk("R2 non-pow2 req log2", req_log2_o, 7);
    chk("R2 non-pow2 cmp log2", cmp_log2_o, 9);

    cfg_clean_i = 1; cfg_data_i = 1; tick(); cfg_clean_i = 0; cfg_data_i = 0;
    req_prod_i = 7; msg_prod_i = 1; msg_cons_i = 0; #1;
    chk("R11 R10 no init", data_init_o, 0);
    chk("R11 req log2", req_log2_o, 0);
    chk("R11 msg log2", msg_log2_o, 0);
    chk("R11 state", state_addr_o, 0);
    chk("R11 req addr", req_addr_o, 0);
    chk("R11 cmp addr", cmp_addr_o, 0);
    chk("R11 msg addr", msg_addr_o, 0);
    chk("R11 room", msg_room_o, 0);
    chk("R11 cons", req_cons_o, 0);
    req_pop_i = 1; tick(); req_pop_i = 0;
    req_flush_i = 1; tick(); req_flush_i = 0;
    chk("R4 no setup pop ignored", req_cons_o, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule